// File: doc/BRIEF.md
# Embedded Operation Status Responder

This block stands in front of a byte-wide nonvolatile array and answers reads while an internal write or erase runs. A one-cycle start request names the operation (byte program, sector erase or whole-array erase) and, for program, the top bit of the byte being written. The block then stays busy for a fixed number of clock cycles and signals completion with a single-cycle done pulse.

While busy, every read strobe returns a status byte instead of array contents. Its top bit is the inverse of the top bit of the byte under program, or zero during any erase (erased cells read as ones, so a one there marks the end). Bit 6 flips on each status read so that software can tell a running operation from a finished one. The remaining bits read as zero. Once the operation ends, reads pass the array byte through again.

A whole-array erase walks the sectors in ascending order and spends a pre-program phase (cells driven to zeros) followed by an erase phase on each one, so its duration is the sector count times the sum of both phase lengths. All durations are parameters given in clock cycles.

Top module: `embop_status_resp`

## Requirements
- R1: After reset, busy_o, done_o and rd_valid_o are low and rd_data_o is 0x00.
- R2: Operation codes on op_i are 0 = byte program, 1 = sector erase, 2 = whole-array erase; a start_i pulse with one of these while busy_o is low makes busy_o high from the next cycle. Code 3 is ignored and leaves busy_o low.
- R3: busy_o stays high for exactly PROG_CYC cycles for program, ERS_CYC for sector erase and N_SECT*(PRE_CYC+ERS_CYC) for whole-array erase; done_o is high for the one cycle right after busy_o's last high cycle and low otherwise.
- R4: A read strobe rd_i sampled high gives rd_valid_o high in the next cycle; if busy_o was low at that sample, rd_data_o equals arr_i as sampled, including on the edge that accepts a start.
- R5: A read sampled while a program is busy returns bit 7 equal to the inverse of the captured prog_msb_i; this holds up to and including busy_o's last high cycle.
- R6: A read sampled while either erase is busy returns bit 7 = 0.
- R7: Bit 6 of status reads is 0 on the first status read after a start and inverts on each later status read of that operation, independent of how many idle cycles lie between reads.
- R8: Bits 5 to 0 of every status read are 0.
- R9: A start_i pulse while busy_o is high changes neither the running operation, its captured data bit nor its duration.
- R10: A whole-array erase visits sectors 0 to N_SECT-1 in order, each a pre-program phase of PRE_CYC cycles followed by an erase phase of ERS_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle operation start request |
| op_i | input | 2 | Operation code (see R2) |
| prog_msb_i | input | 1 | Bit 7 of the byte to be programmed |
| rd_i | input | 1 | Read strobe, one cycle per read access |
| arr_i | input | 8 | Array byte for the address being read |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_i |
| rd_data_o | output | 8 | Read result: status byte or array byte |

## Verification
The bench reads on the very edge that accepts a start and on busy_o's last high cycle; a design off by one in either place returns status where array data belongs or the reverse. Reads spaced by idle cycles catch a toggle bit that runs off the clock instead of the read strobe, and a start issued mid-program with a different operation and data bit exposes a design that reloads its captured state. A whole-array erase timed end to end catches a sequencer that skips the pre-program phase, drops a sector or adds a gap cycle between phases.

// File: rtl/embop_pkg.sv
package embop_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2,
    OP_RSVD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PROG  = 2'd1,
    PH_PREP  = 2'd2,
    PH_ERASE = 2'd3
  } phase_e;

  function automatic logic op_valid(op_e op);
    return op != OP_RSVD;
  endfunction

  function automatic phase_e first_phase(op_e op);
    case (op)
      OP_PROG:   return PH_PROG;
      OP_CERASE: return PH_PREP;
      default:   return PH_ERASE;
    endcase
  endfunction

  // Status byte presented while an operation runs.
  function automatic logic [7:0] poll_byte(op_e op, logic msb, logic tog);
    logic b7;
    b7 = (op == OP_PROG) ? ~msb : 1'b0;
    return {b7, tog, 6'b0};
  endfunction

  // Whole busy duration of an operation in cycles.
  function automatic int unsigned total_cycles(op_e op, int unsigned prog,
                                               int unsigned pre, int unsigned ers,
                                               int unsigned nsect);
    case (op)
      OP_PROG:   return prog;
      OP_SERASE: return ers;
      OP_CERASE: return nsect * (pre + ers);
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/embop_timer.sv
module embop_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expire_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= len_i - CW'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/embop_seq.sv
module embop_seq
  import embop_pkg::*;
#(
  parameter int unsigned PROG_CYC = 20,
  parameter int unsigned PRE_CYC  = 12,
  parameter int unsigned ERS_CYC  = 60,
  parameter int unsigned N_SECT   = 4,
  parameter int unsigned CW       = 8,
  parameter int unsigned SW       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  op_e           new_op_i,
  input  op_e           cur_op_i,
  input  logic          expire_i,
  output phase_e        phase_o,
  output logic [SW-1:0] sect_o,
  output logic          load_o,
  output logic [CW-1:0] len_o,
  output logic          finish_o
);
  logic   last_sect, last_ph;
  phase_e nxt_ph;

  function automatic logic [CW-1:0] len_of(phase_e ph);
    case (ph)
      PH_PROG: return CW'(PROG_CYC);
      PH_PREP: return CW'(PRE_CYC);
      default: return CW'(ERS_CYC);
    endcase
  endfunction

  always_comb begin
    last_sect = (sect_o == SW'(N_SECT - 1));
    last_ph   = (phase_o == PH_PROG) ||
                ((phase_o == PH_ERASE) && ((cur_op_i != OP_CERASE) || last_sect));
    nxt_ph    = (phase_o == PH_PREP) ? PH_ERASE : PH_PREP;
    finish_o  = expire_i && last_ph;
    load_o    = accept_i || (expire_i && !last_ph);
    len_o     = accept_i ? len_of(first_phase(new_op_i)) : len_of(nxt_ph);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= PH_IDLE;
      sect_o  <= '0;
    end else if (accept_i) begin
      phase_o <= first_phase(new_op_i);
      sect_o  <= '0;
    end else if (expire_i) begin
      if (last_ph) begin
        phase_o <= PH_IDLE;
      end else begin
        phase_o <= nxt_ph;
        if (phase_o == PH_ERASE) sect_o <= sect_o + SW'(1);
      end
    end
  end
endmodule

// File: rtl/embop_reader.sv
module embop_reader
  import embop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       rd_i,
  input  logic       busy_i,
  input  op_e        op_i,
  input  logic       msb_i,
  input  logic [7:0] arr_i,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  output logic       stat_vld_o
);
  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q      <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      stat_vld_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      stat_vld_o <= rd_i && busy_i;
      if (clr_i)                tog_q <= 1'b0;
      else if (rd_i && busy_i)  tog_q <= ~tog_q;
      if (rd_i) rd_data_o <= busy_i ? poll_byte(op_i, msb_i, tog_q) : arr_i;
    end
  end
endmodule

// File: rtl/embop_status_resp.sv
module embop_status_resp
  import embop_pkg::*;
#(
  parameter int unsigned PROG_CYC = 20,
  parameter int unsigned PRE_CYC  = 12,
  parameter int unsigned ERS_CYC  = 60,
  parameter int unsigned N_SECT   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic       prog_msb_i,
  input  logic       rd_i,
  input  logic [7:0] arr_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o
);
  localparam int unsigned MAX_A   = (PROG_CYC > PRE_CYC) ? PROG_CYC : PRE_CYC;
  localparam int unsigned MAX_LEN = (MAX_A > ERS_CYC) ? MAX_A : ERS_CYC;
  localparam int unsigned CW      = $clog2(MAX_LEN + 1);
  localparam int unsigned SW      = (N_SECT > 1) ? $clog2(N_SECT) : 1;

  op_e           op_in, op_q;
  logic          msb_q, accept, tmr_load, tmr_expire, seq_finish, stat_vld;
  logic [CW-1:0] tmr_len;
  phase_e        phase_q;
  logic [SW-1:0] sect_q;

  assign op_in  = op_e'(op_i);
  assign busy_o = (phase_q != PH_IDLE);
  assign accept = start_i && !busy_o && op_valid(op_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PROG;
      msb_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= seq_finish;
      if (accept) begin
        op_q  <= op_in;
        msb_q <= prog_msb_i;
      end
    end
  end

  embop_seq #(
    .PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC),
    .N_SECT(N_SECT), .CW(CW), .SW(SW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .new_op_i(op_in),
    .cur_op_i(op_q), .expire_i(tmr_expire), .phase_o(phase_q),
    .sect_o(sect_q), .load_o(tmr_load), .len_o(tmr_len), .finish_o(seq_finish)
  );

  embop_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .len_i(tmr_len),
    .expire_o(tmr_expire)
  );

  embop_reader u_rd (
    .clk(clk), .rst_n(rst_n), .clr_i(accept), .rd_i(rd_i), .busy_i(busy_o),
    .op_i(op_q), .msb_i(msb_q), .arr_i(arr_i), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .stat_vld_o(stat_vld)
  );
endmodule

// File: rtl/embop_status_chk.sv
module embop_status_chk
  import embop_pkg::*;
#(
  parameter int unsigned PROG_CYC = 20,
  parameter int unsigned PRE_CYC  = 12,
  parameter int unsigned ERS_CYC  = 60,
  parameter int unsigned N_SECT   = 4,
  parameter int unsigned SW       = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [1:0]    op_i,
  input logic          rd_i,
  input logic [7:0]    arr_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          rd_valid_o,
  input logic [7:0]    rd_data_o,
  input logic          accept,
  input op_e           op_q,
  input logic          msb_q,
  input phase_e        phase,
  input logic [SW-1:0] sect,
  input logic          expire,
  input logic          stat_vld
);
  int unsigned run_q;
  logic        seen_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 0;
      seen_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      run_q <= busy_o ? run_q + 1 : 0;
      if (accept) seen_q <= 1'b0;
      else if (stat_vld) begin
        seen_q <= 1'b1;
        last_q <= rd_data_o[6];
      end
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o); // R2
  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && op_i == 2'd3) |=> !busy_o); // R2
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(busy_o)); // R3
  AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R3
  AST_DURATION: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_q == total_cycles(op_q, PROG_CYC, PRE_CYC, ERS_CYC, N_SECT)); // R3
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rd_valid_o); // R4
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !busy_o) |=> rd_data_o == $past(arr_i)); // R4
  AST_PROG_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && busy_o && op_q == OP_PROG) |=> rd_data_o[7] == !$past(msb_q)); // R5
  AST_ERASE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && busy_o && op_q != OP_PROG) |=> !rd_data_o[7]); // R6
  AST_TOGGLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && !seen_q) |-> !rd_data_o[6]); // R7
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && seen_q) |-> rd_data_o[6] != last_q); // R7
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |-> rd_data_o[5:0] == 6'd0); // R8
  AST_BUSY_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(op_q) && $stable(msb_q))); // R9
  AST_PREP_THEN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PREP && expire) |=> (phase == PH_ERASE && $stable(sect))); // R10
  AST_NEXT_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ERASE && expire && op_q == OP_CERASE && sect != SW'(N_SECT - 1))
    |=> (phase == PH_PREP && sect == $past(sect) + SW'(1))); // R10
  AST_SECT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sect) < N_SECT); // R10
endmodule

bind embop_status_resp embop_status_chk #(
  .PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC),
  .N_SECT(N_SECT), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .rd_i(rd_i),
  .arr_i(arr_i), .busy_o(busy_o), .done_o(done_o), .rd_valid_o(rd_valid_o),
  .rd_data_o(rd_data_o), .accept(accept), .op_q(op_q), .msb_q(msb_q),
  .phase(phase_q), .sect(sect_q), .expire(tmr_expire), .stat_vld(stat_vld)
);

// File: tb/embop_status_resp_tb.sv
module embop_status_resp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P_PROG = 20;
  localparam int P_PRE  = 12;
  localparam int P_ERS  = 60;
  localparam int P_NS   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, prog_msb_i = 0, rd_i = 0;
  logic [1:0] op_i = 0;
  logic [7:0] arr_i = 0;
  logic busy_o, done_o, rd_valid_o;
  logic [7:0] rd_data_o;

  embop_status_resp #(.PROG_CYC(P_PROG), .PRE_CYC(P_PRE), .ERS_CYC(P_ERS), .N_SECT(P_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .prog_msb_i(prog_msb_i),
    .rd_i(rd_i), .arr_i(arr_i), .busy_o(busy_o), .done_o(done_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, n_chk = 0, n_err = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Bench model of the running operation (edge numbers)
  int m_s = -100000, m_dur = 0;
  logic [1:0] m_op = 0;
  logic m_msb = 0, m_tog = 0;

  typedef struct { int e; logic [7:0] v; string tag; } exp_t;
  exp_t sb[$];

  function automatic int dur_of(logic [1:0] op);
    if (op == 2'd0) return P_PROG;
    if (op == 2'd1) return P_ERS;
    return P_NS * P_PRE + P_NS * P_ERS;
  endfunction

  function automatic bit m_busy(int e);
    return (e > m_s) && (e <= m_s + m_dur);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit st, input logic [1:0] op, input logic msb,
                       input bit rd, input logic [7:0] arr, input string tag);
    int e;
    exp_t it;
    @(negedge clk);
    e = cyc + 1;
    if (st && !m_busy(e) && op != 2'd3) begin
      m_s = e; m_dur = dur_of(op); m_op = op; m_msb = msb; m_tog = 1'b0;
    end
    if (rd) begin
      it.e = e; it.tag = tag;
      if (m_busy(e)) begin
        it.v = {(m_op == 2'd0) ? ~m_msb : 1'b0, m_tog, 6'b0};
        m_tog = ~m_tog;
      end else it.v = arr;
      sb.push_back(it);
    end
    start_i = st; op_i = op; prog_msb_i = msb; rd_i = rd; arr_i = arr;
  endtask

  task automatic idle(); drive(0, 2'd0, 1'b0, 0, 8'h00, ""); endtask
  task automatic rd(input logic [7:0] a, input string tag); drive(0, 2'd0, 1'b0, 1, a, tag); endtask
  task automatic go(input logic [1:0] op, input logic msb); drive(1, op, msb, 0, 8'h00, ""); endtask
  task automatic wait_edge(input int target); while (cyc + 2 < target) idle(); endtask

  // Scoreboard monitor for reads
  always @(negedge clk) begin
    if (rst_n) begin
      if (sb.size() > 0 && sb[0].e == cyc) begin
        exp_t it;
        it = sb.pop_front();
        chk(rd_valid_o == 1'b1 && rd_data_o == it.v, it.tag, {rd_valid_o, rd_data_o}, {1'b1, it.v});
      end else if (rd_valid_o) begin
        chk(1'b0, "R4 unexpected rd_valid_o", 1, 0);
      end
    end
  end

  // Busy-length and done monitor
  bit prev_busy = 0;
  int run_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) run_len++;
      if (prev_busy && !busy_o) begin
        chk(run_len == m_dur, "R3 R10 busy length", run_len, m_dur);
        chk(done_o == 1'b1, "R3 done at end", done_o, 1);
        run_len = 0;
      end else if (done_o) begin
        chk(1'b0, "R3 stray done", 1, 0);
      end
      prev_busy = busy_o;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=<50000", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && rd_valid_o == 0 && rd_data_o == 8'h00,
        "R1 reset state", {busy_o, done_o, rd_valid_o, rd_data_o}, 0);
    rst_n = 1'b1;
    idle(); idle();
    rd(8'h5A, "R4 idle read");
    idle();

    // Program, captured bit 7 = 0 -> status bit 7 = 1
    drive(1, 2'd0, 1'b0, 1, 8'h11, "R4 read on accept edge");
    idle();
    chk(busy_o == 1'b1, "R2 program accepted", busy_o, 1);
    rd(8'h00, "R5 R7 R8 first status");
    rd(8'h00, "R5 R7 second status");
    rd(8'h00, "R5 R7 third status");
    idle(); idle(); idle();
    rd(8'h00, "R7 toggle per read not per clock");
    drive(1, 2'd1, 1'b1, 1, 8'h00, "R9 start while busy");
    rd(8'h00, "R9 operation unchanged");
    wait_edge(m_s + m_dur);
    rd(8'h22, "R5 last busy cycle");
    rd(8'h33, "R4 after done");
    idle(); idle(); idle();

    // Sector erase
    go(2'd1, 1'b1);
    idle();
    chk(busy_o == 1'b1, "R2 sector erase accepted", busy_o, 1);
    rd(8'hFF, "R6 R7 R8 erase status");
    rd(8'hFF, "R6 R7 erase status 2");
    wait_edge(m_s + m_dur);
    rd(8'h44, "R6 last busy cycle");
    rd(8'h66, "R4 after erase");
    idle(); idle(); idle();

    // Whole-array erase
    go(2'd2, 1'b0);
    idle();
    chk(busy_o == 1'b1, "R2 chip erase accepted", busy_o, 1);
    rd(8'hAA, "R6 R10 chip erase status");
    wait_edge(m_s + P_PRE + P_ERS + 2);
    rd(8'hAA, "R6 R10 second sector status");
    wait_edge(m_s + m_dur);
    rd(8'hBB, "R10 last busy cycle");
    rd(8'hCC, "R4 R10 after chip erase");
    idle(); idle(); idle();

    // Reserved code
    go(2'd3, 1'b1);
    idle();
    chk(busy_o == 1'b0, "R2 reserved code ignored", busy_o, 0);
    rd(8'hC3, "R2 R4 array after reserved code");
    idle(); idle();

    // Program with bit 7 = 1 -> status bit 7 = 0, read every cycle
    go(2'd0, 1'b1);
    for (int i = 0; i < P_PROG + 2; i++) rd(8'h7E, "R5 R7 R8 dense polling");
    idle(); idle(); idle(); idle();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule